// File: doc/BRIEF.md
# Programmable Liveness Heartbeat Generator

This block produces a slow square-wave heartbeat on an open-drain pin so that an external controller can confirm that the signal processor is alive and processing audio. The controller watches the pin. When the pulses stop or arrive at the wrong rate, the controller resets the processor and configures it again.

The heartbeat period is set in whole milliseconds, from 0 to 100 ms, through a one-cycle write strobe. After reset the period is 100 ms. The block does not time the period with the system clock. It counts audio sample ticks and converts milliseconds into ticks using the configured sample rate (32 kHz, 44.1 kHz or 48 kHz). As a result, the heartbeat stops when the audio clocks stop, and a stalled audio input in slave operation appears to the controller as a missing heartbeat. The heartbeat runs only while the processing-active flag is high.

A period of 0 switches the heartbeat off and leaves the pin released. Each period write starts the waveform again from the beginning of the released phase.

Top module: `heartbeat_gen`

## Requirements
- R1: After reset, the pin is released (`od_pull_low` = 0) and the period is 100 ms.
- R2: A half-period lasts `ceil(ms * K / 20)` sample ticks. K is set by `rate_sel`: 0 gives K=320 (32 kHz), 1 gives K=441 (44.1 kHz), and 2 or 3 give K=480 (48 kHz).
- R3: The waveform starts in the released phase. The output toggles when the tick that completes each half-period arrives, so the pin is pulled low (`od_pull_low` = 1) during every second half-period.
- R4: A written period above 100 ms is stored as 100 ms.
- R5: A period write clears the tick count. In the clock after the write strobe, the pin is released.
- R6: While the stored period is 0, the pin stays released whatever ticks arrive.
- R7: While `proc_active` is 0, the pin is released in the following clock and the tick count is held at zero. When the flag returns to 1, a fresh released half-period begins.
- R8: Without a sample tick, the output level does not change.
- R9: The output changes in the clock edge that samples the completing sample tick, and in no other cycle except those covered by R5 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_wr | input | 1 | One-cycle strobe that loads `period_ms` |
| period_ms | input | 7 | Requested period in milliseconds (clamped to 100) |
| rate_sel | input | 2 | Sample rate code: 0 = 32 kHz, 1 = 44.1 kHz, 2 or 3 = 48 kHz |
| proc_active | input | 1 | High while the processor is in normal processing |
| sample_tick | input | 1 | One-cycle pulse per audio sample, synchronous to `clk` |
| od_pull_low | output | 1 | Open-drain enable: 1 drives the pin low, 0 releases it |

## Verification
The assertions assume four things about the inputs:
- `sample_tick` is already synchronous to `clk`.
- `rate_sel` changes only while the heartbeat is idle or just before a period write.
- No period write lands on the same cycle as a tick that is expected to toggle the output.
- `proc_active` is a level that is held for several clocks.

The stimulus meets these assumptions in the following ways:
- Ticks are driven at most every second clock.
- The rate is changed only ahead of a write.
- Writes, activity changes and tick gaps are issued between ticks, never on a tick cycle.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        RATE_32K   = 2'd0,
        RATE_44K1  = 2'd1,
        RATE_48K   = 2'd2,
        RATE_48K_B = 2'd3
    } rate_e;

    // Each sample tick adds this many units to the accumulator.
    // A half-period target is ms * (ticks per 10 ms).
    localparam int unsigned HALF_STEP = 20;

    localparam int unsigned MAX_TICKS_10MS = 480;

    function automatic int unsigned ticks_per_10ms(input rate_e r);
        case (r)
            RATE_32K:  return 320;
            RATE_44K1: return 441;
            default:   return 480;
        endcase
    endfunction

endpackage

// File: rtl/hb_period_reg.sv
module hb_period_reg #(
    parameter int unsigned MAX_MS = 100,
    parameter int unsigned DEF_MS = 100,
    localparam int unsigned MS_W  = $clog2(MAX_MS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [MS_W-1:0] wdata,
    output logic [MS_W-1:0] ms_q,
    output logic            ms_zero
);

    typedef struct packed {
        logic [MS_W-1:0] ms;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (32'(wdata) > MAX_MS) st_d.ms = MS_W'(MAX_MS);
            else                     st_d.ms = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{ms: MS_W'(DEF_MS)};
        else        st_q <= st_d;
    end

    assign ms_q    = st_q.ms;
    assign ms_zero = (st_q.ms == '0);

endmodule

// File: rtl/hb_scale.sv
module hb_scale #(
    parameter int unsigned MS_W  = 7,
    parameter int unsigned TGT_W = 16
) (
    input  logic [MS_W-1:0]  ms,
    input  logic [1:0]       rate_sel,
    output logic [TGT_W-1:0] target
);
    import hb_pkg::*;

    logic [TGT_W-1:0] k;

    always_comb begin
        k      = TGT_W'(ticks_per_10ms(rate_e'(rate_sel)));
        target = TGT_W'(ms) * k;
    end

endmodule

// File: rtl/hb_phase_core.sv
module hb_phase_core #(
    parameter int unsigned TGT_W = 16,
    parameter int unsigned STEP  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic             restart,
    input  logic             off,
    input  logic [TGT_W-1:0] target,
    output logic             low
);

    typedef struct packed {
        logic [TGT_W-1:0] acc;
        logic             low;
    } core_t;

    core_t st_d, st_q;
    logic [TGT_W:0] sum_d;

    always_comb begin
        st_d  = st_q;
        sum_d = {1'b0, st_q.acc} + (TGT_W + 1)'(STEP);
        if (restart || !active || off) begin
            st_d.acc = '0;
            st_d.low = 1'b0;
        end else if (tick) begin
            if (sum_d >= {1'b0, target}) begin
                st_d.acc = '0;
                st_d.low = ~st_q.low;
            end else begin
                st_d.acc = sum_d[TGT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{acc: '0, low: 1'b0};
        else        st_q <= st_d;
    end

    assign low = st_q.low;

endmodule

// File: rtl/heartbeat_gen.sv
module heartbeat_gen #(
    parameter int unsigned MAX_MS = 100,
    parameter int unsigned DEF_MS = 100,
    localparam int unsigned MS_W  = $clog2(MAX_MS + 1),
    localparam int unsigned TGT_W = $clog2(MAX_MS * hb_pkg::MAX_TICKS_10MS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            period_wr,
    input  logic [MS_W-1:0] period_ms,
    input  logic [1:0]      rate_sel,
    input  logic            proc_active,
    input  logic            sample_tick,
    output logic            od_pull_low
);

    logic [MS_W-1:0]  ms_cur;
    logic             ms_off;
    logic [TGT_W-1:0] half_tgt;

    hb_period_reg #(.MAX_MS(MAX_MS), .DEF_MS(DEF_MS)) u_preg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (period_wr),
        .wdata   (period_ms),
        .ms_q    (ms_cur),
        .ms_zero (ms_off)
    );

    hb_scale #(.MS_W(MS_W), .TGT_W(TGT_W)) u_scale (
        .ms       (ms_cur),
        .rate_sel (rate_sel),
        .target   (half_tgt)
    );

    hb_phase_core #(.TGT_W(TGT_W), .STEP(hb_pkg::HALF_STEP)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sample_tick),
        .active  (proc_active),
        .restart (period_wr),
        .off     (ms_off),
        .target  (half_tgt),
        .low     (od_pull_low)
    );

endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
    parameter int unsigned MAX_MS = 100,
    parameter int unsigned MS_W   = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            period_wr,
    input logic            proc_active,
    input logic            sample_tick,
    input logic [MS_W-1:0] ms_cur,
    input logic            od_pull_low
);

    // R4
    period_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ms_cur) <= MAX_MS);

    // R5
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> !od_pull_low);

    // R6
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_cur == '0) |-> !od_pull_low);

    // R7
    inactive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_active |=> !od_pull_low);

    // R8
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !period_wr && proc_active) |=> $stable(od_pull_low));

    // R9
    pull_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_pull_low) |-> $past(sample_tick));

endmodule

bind heartbeat_gen hb_chk #(.MAX_MS(MAX_MS), .MS_W(MS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .period_wr   (period_wr),
    .proc_active (proc_active),
    .sample_tick (sample_tick),
    .ms_cur      (ms_cur),
    .od_pull_low (od_pull_low)
);

// File: tb/sim_heartbeat_gen.sv
module sim_heartbeat_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       period_wr = 1'b0;
    logic [6:0] period_ms = '0;
    logic [1:0] rate_sel = 2'd0;
    logic       proc_active = 1'b0;
    logic       sample_tick = 1'b0;
    logic       od_pull_low;

    always #10 clk = ~clk;

    heartbeat_gen u0 (
        .clk(clk), .rst_n(rst_n), .period_wr(period_wr), .period_ms(period_ms),
        .rate_sel(rate_sel), .proc_active(proc_active),
        .sample_tick(sample_tick), .od_pull_low(od_pull_low)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic  pend  = 1'b0;

    // bench reference model
    int m_ms = 100;
    int m_rate = 0;
    int m_cnt = 0;
    bit m_low = 1'b0;
    bit m_act = 1'b0;

    function automatic int half_ticks(int ms, int rate);
        int k;
        k = (rate == 0) ? 320 : (rate == 1) ? 441 : 480;
        return (ms * k + 19) / 20;
    endfunction

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: od_pull_low=%0b expected %0b", tag, got, exp);
        end
    endtask

    // driver: one sample tick, expected result queued for the monitor
    task automatic drive_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            item_t it;
            @(negedge clk);
            sample_tick = 1'b1;
            if (m_act && m_ms != 0) begin
                m_cnt++;
                if (m_cnt >= half_ticks(m_ms, m_rate)) begin
                    m_cnt = 0;
                    m_low = !m_low;
                end
            end
            it.exp = m_low;
            it.tag = tag;
            exp_q.push_back(it);
            @(negedge clk);
            sample_tick = 1'b0;
        end
    endtask

    task automatic write_period(input int ms);
        @(negedge clk);
        period_wr = 1'b1;
        period_ms = 7'(ms);
        @(negedge clk);
        period_wr = 1'b0;
        m_ms  = (ms > 100) ? 100 : ms;
        m_cnt = 0;
        m_low = 1'b0;
        chk(od_pull_low, 1'b0, "R5 write release");
    endtask

    task automatic set_active(input bit a);
        @(negedge clk);
        proc_active = a;
        @(negedge clk);
        m_act = a;
        if (!a) begin
            m_cnt = 0;
            m_low = 1'b0;
        end
        chk(od_pull_low, m_low, "R7 activity change");
    endtask

    // monitor
    always @(posedge clk) pend <= sample_tick;

    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R9: unexpected tick result, od_pull_low=%0b expected none", od_pull_low);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(od_pull_low, it.exp, it.tag);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, done=0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(od_pull_low, 1'b0, "R1 reset released");
        rst_n = 1'b1;
        @(negedge clk);
        chk(od_pull_low, 1'b0, "R1 after reset");

        // R1 default 100 ms at 32 kHz: 1600-tick halves
        rate_sel = 2'd0;
        m_rate = 0;
        set_active(1'b1);
        drive_ticks(3300, "R1 R3 default period");

        // R2 48 kHz, 2 ms: 48-tick halves
        rate_sel = 2'd2;
        m_rate = 2;
        write_period(2);
        drive_ticks(200, "R2 R3 48k 2ms");

        // R2 44.1 kHz, 1 ms: ceil(22.05)=23
        rate_sel = 2'd1;
        m_rate = 1;
        write_period(1);
        drive_ticks(100, "R2 R9 44k1 1ms");

        // R8 tick gap: level held
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(od_pull_low, m_low, "R8 no tick hold");
        end

        // R2 code 3 behaves as 48 kHz
        rate_sel = 2'd3;
        m_rate = 3;
        write_period(1);
        drive_ticks(60, "R2 code3 48k");

        // R6 zero period
        write_period(0);
        drive_ticks(50, "R6 zero period");

        // R7 inactive while low
        rate_sel = 2'd0;
        m_rate = 0;
        write_period(3);
        drive_ticks(60, "R3 32k 3ms");
        set_active(1'b0);
        drive_ticks(20, "R7 inactive");
        set_active(1'b1);
        drive_ticks(60, "R7 fresh start");

        // R5 write during low phase
        write_period(2);
        drive_ticks(40, "R5 restart");
        write_period(2);
        drive_ticks(40, "R5 restart count");

        // R4 clamp: 120 stored as 100 -> 2400-tick halves at 48 kHz
        rate_sel = 2'd2;
        m_rate = 2;
        write_period(120);
        drive_ticks(2500, "R4 clamp");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule